// File: doc/BRIEF.md
# Broadcast-Feedback Recursive Filter Lane Row

This block evaluates the recursive half of an IIR filter on a row of multiply-accumulate lanes. For each accepted input sample `u_k` (the already computed feed-forward part) it returns `y_k = u_k + sum over j = 1..N of a_j * y_(k-j)`. N is the active tap count, between 0 and the number of lanes. Coefficients are signed Q2.14 values and samples are 16-bit signed integers.

Lane `p` keeps coefficient `a_(p+1)` for the whole run. On every accepted sample, the previous output is broadcast to all lanes. Each lane adds its coefficient times that value to its partial sum. The partial sums then move one lane toward lane 0, and the top lane refills with zero. Lane 0 finishes the current output and stores it so that it can be broadcast on the next accepted sample. The outputs of a run before its first sample are taken as zero.

Software first writes the coefficients. It then pulses `start` with a tap count and a run length, and streams samples with a valid flag. Gaps in the input stream are allowed. The outputs come back with a valid flag and a last-of-run marker.

Top module: `recur_lane_filter`

## Requirements
- R1: After reset `out_valid`, `out_last` and `busy` are 0.
- R2: An accepted sample `u_k` gives `y_k = sat16(floor((u_k*2^14 + sum_j a_j*y_(k-j) + 2^13) / 2^14))`. Lane index `coef_sel = p` holds `a_(p+1)`, and coefficients are signed Q2.14.
- R3: `start` clears all partial sums and the stored output, so a run's first output is its first sample rounded, with all earlier outputs taken as zero.
- R4: Lanes with index at or above the active tap count contribute nothing. A tap count above the lane count is treated as the lane count.
- R5: Coefficient writes are ignored while `busy` is 1.
- R6: Results above 32767 are clamped to 32767 and results below -32768 to -32768. The clamped value is also the value fed back.
- R7: A sample is accepted when `busy` and `in_valid` are 1 and `start` is 0. Its output appears with `out_valid` exactly one cycle later. Cycles without an accepted sample leave the filter state unchanged and give `out_valid` 0.
- R8: `start` with a nonzero `cfg_len` sets `busy` on the next cycle. `busy` clears on the edge that accepts the `cfg_len`-th sample, and that sample's output carries `out_last`. A zero length leaves `busy` at 0. Samples offered while `busy` is 0 are ignored.
- R9: `start` during a run restarts it, drops any sample offered in the same cycle, and uses the new tap count and length.
- R10: All lanes can be active at once (tap count equal to the lane count).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run, clears the filter history |
| cfg_taps | input | 5 | Active tap count, sampled on start |
| cfg_len | input | 16 | Samples in the run, sampled on start |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 4 | Lane index for the write |
| coef_val | input | 16 | Signed Q2.14 coefficient |
| in_valid | input | 1 | Input sample valid |
| in_sample | input | 16 | Signed feed-forward sample |
| out_valid | output | 1 | Output sample valid |
| out_sample | output | 16 | Signed filter output |
| out_last | output | 1 | Marks the final output of a run |
| busy | output | 1 | Run in progress |

## Verification
Every output is due in the cycle after the edge that accepted its sample. `busy` responds on the first edge after `start` or after the final sample. The bench drives inputs just after each rising edge. Before that edge it advances a behavioural model by one step, using integer history queues. About 1 ns after the edge it compares `out_valid`, `busy`, `out_sample` and `out_last` with the model. Each check therefore covers exactly one register stage.

// File: rtl/recur_lane_filter.sv
module recur_lane_filter #(
  parameter int LANES = 16,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int FRAC  = 14,
  parameter int AW    = 40,
  parameter int LW    = 16,
  localparam int SW   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int TW   = $clog2(LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [TW-1:0]        cfg_taps,
  input  logic [LW-1:0]        cfg_len,
  input  logic                 coef_we,
  input  logic [SW-1:0]        coef_sel,
  input  logic signed [CW-1:0] coef_val,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_sample,
  output logic                 out_last,
  output logic                 busy
);

  localparam logic signed [AW-1:0] HALF = AW'(1) << (FRAC - 1);
  localparam logic signed [AW-1:0] YMAX = AW'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [AW-1:0] YMIN = -YMAX - AW'(1);

  logic [LANES*CW-1:0]  coef_q;
  logic signed [AW-1:0] acc_q [LANES];
  logic signed [AW-1:0] sum_w [LANES+1];
  logic signed [DW-1:0] fb_q;
  logic [TW-1:0]        taps_q;
  logic [LW-1:0]        left_q;
  logic signed [AW-1:0] pre_w, rnd_w;
  logic signed [DW-1:0] y_w;

  wire take = busy & in_valid & ~start;

  for (genvar p = 0; p < LANES; p++) begin : g_lane
    logic signed [CW-1:0]    c;
    logic signed [CW+DW-1:0] prod;
    assign c        = (taps_q > TW'(p)) ? coef_q[p*CW +: CW] : '0;
    assign prod     = c * fb_q;
    assign sum_w[p] = acc_q[p] + AW'(prod);
  end
  assign sum_w[LANES] = '0;

  assign pre_w = (AW'(in_sample) <<< FRAC) + sum_w[0] + HALF;
  assign rnd_w = pre_w >>> FRAC;
  assign y_w   = (rnd_w > YMAX) ? DW'(YMAX) :
                 (rnd_w < YMIN) ? DW'(YMIN) : rnd_w[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      for (int p = 0; p < LANES; p++) acc_q[p] <= '0;
    end else if (take) begin
      for (int p = 0; p < LANES; p++) acc_q[p] <= sum_w[p+1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coef_q <= '0;
    end else if (coef_we && !busy && int'(coef_sel) < LANES) begin
      coef_q[int'(coef_sel)*CW +: CW] <= coef_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      taps_q     <= '0;
      left_q     <= '0;
      fb_q       <= '0;
      out_valid  <= 1'b0;
      out_last   <= 1'b0;
      out_sample <= '0;
    end else if (start) begin
      busy      <= (cfg_len != '0);
      taps_q    <= (int'(cfg_taps) > LANES) ? TW'(LANES) : cfg_taps;
      left_q    <= cfg_len;
      fb_q      <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else if (take) begin
      fb_q       <= y_w;
      out_sample <= y_w;
      out_valid  <= 1'b1;
      out_last   <= (left_q == LW'(1));
      left_q     <= left_q - LW'(1);
      if (left_q == LW'(1)) busy <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end

endmodule

// File: rtl/recur_lane_filter_chk.sv
module recur_lane_filter_chk #(
  parameter int LANES = 16,
  parameter int CW    = 16,
  parameter int LW    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [LW-1:0]       cfg_len,
  input logic                in_valid,
  input logic                busy,
  input logic                out_valid,
  input logic                out_last,
  input logic [LANES*CW-1:0] coef_q
);

  p_valid_follows_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(busy && in_valid && !start));

  p_coef_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(coef_q));

  p_start_arms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cfg_len != '0) |=> busy);

  p_last_ends_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && !busy));

  p_restart_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !out_valid);

endmodule

bind recur_lane_filter recur_lane_filter_chk #(.LANES(LANES), .CW(CW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len), .in_valid(in_valid),
  .busy(busy), .out_valid(out_valid), .out_last(out_last), .coef_q(coef_q)
);

// File: tb/recur_lane_filter_test.sv
`timescale 1ns/1ps
module recur_lane_filter_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4:0] cfg_taps = '0;
  logic [15:0] cfg_len = '0;
  logic coef_we = 1'b0;
  logic [3:0] coef_sel = '0;
  logic signed [15:0] coef_val = '0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic out_valid, out_last, busy;
  logic signed [15:0] out_sample;

  always #2.5 clk = ~clk;

  recur_lane_filter uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_taps(cfg_taps), .cfg_len(cfg_len),
    .coef_we(coef_we), .coef_sel(coef_sel), .coef_val(coef_val), .in_valid(in_valid),
    .in_sample(in_sample), .out_valid(out_valid), .out_sample(out_sample),
    .out_last(out_last), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  longint mcoef [16];
  longint hist [16];
  int mtaps = 0, mleft = 0;
  bit mbusy = 0, ev = 0, el = 0;
  longint ey = 0;

  task automatic check(input bit ok, input longint act, input longint exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit was_busy = mbusy;
    ev = 0; el = 0;
    if (start) begin
      mbusy = (cfg_len != 0);
      mleft = cfg_len;
      mtaps = (cfg_taps > 16) ? 16 : int'(cfg_taps);
      for (int j = 0; j < 16; j++) hist[j] = 0;
    end else if (mbusy && in_valid) begin
      longint s = 0, v;
      for (int j = 0; j < mtaps; j++) s += mcoef[j] * hist[j];
      v = (longint'(in_sample) * 16384) + s + 8192;
      v = v >>> 14;
      if (v > 32767) v = 32767;
      if (v < -32768) v = -32768;
      for (int j = 15; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = v;
      ev = 1; ey = v;
      el = (mleft == 1);
      mleft--;
      if (mleft == 0) mbusy = 0;
    end
    if (coef_we && !was_busy) mcoef[coef_sel] = longint'(coef_val);
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    #1;
    check(out_valid == ev, out_valid, ev, "out_valid");
    check(busy == mbusy, busy, mbusy, "busy");
    if (ev) begin
      check(out_sample == ey, out_sample, ey, "out_sample");
      check(out_last == el, out_last, el, "out_last");
    end
    start = 0; coef_we = 0; in_valid = 0;
  endtask

  task automatic load(input int sel, input int val);
    coef_we = 1; coef_sel = 4'(sel); coef_val = 16'(val);
    tick();
  endtask

  task automatic go(input int taps, input int len);
    start = 1; cfg_taps = 5'(taps); cfg_len = 16'(len);
    tick();
  endtask

  task automatic feed(input int x);
    in_valid = 1; in_sample = 16'(x);
    tick();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int j = 0; j < 16; j++) begin mcoef[j] = 0; hist[j] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tag = "R1";
    tick();
    check(out_last == 0, out_last, 0, "out_last after reset");

    tag = "R2";
    load(0, 8192); load(1, -4096); load(2, 2048);
    go(3, 12);
    feed(1000);
    for (int i = 0; i < 5; i++) feed(0);
    feed(-700); feed(300); feed(32); feed(-5); feed(1); feed(2);

    tag = "R7";
    go(3, 10);
    for (int i = 0; i < 10; i++) begin
      feed(400 - 90 * i);
      if (i % 3 == 0) begin tick(); tick(); end
    end

    tag = "R4";
    for (int p = 3; p < 16; p++) load(p, 16000);
    go(3, 6);
    for (int i = 0; i < 6; i++) feed(1500 + 100 * i);
    for (int p = 3; p < 16; p++) load(p, 0);
    go(20, 5);
    for (int i = 0; i < 5; i++) feed(1000 - 300 * i);

    tag = "R5";
    go(3, 8);
    feed(2000);
    load(0, -16000); load(1, 12000);
    for (int i = 0; i < 6; i++) feed(-100 * i);
    feed(77);

    tag = "R6";
    load(0, 24576); load(1, 0); load(2, 0);
    go(1, 10);
    for (int i = 0; i < 5; i++) feed(20000);
    for (int i = 0; i < 5; i++) feed(-30000);

    tag = "R8";
    in_valid = 1; in_sample = 16'sd1234; tick();
    go(1, 0);
    in_valid = 1; in_sample = 16'sd55; tick();
    load(0, 4096);
    go(1, 3);
    feed(100); tick(); feed(200); feed(300);
    feed(999); tick();

    tag = "R9";
    go(1, 20);
    feed(5000); feed(6000); feed(-200);
    start = 1; cfg_taps = 5'd1; cfg_len = 16'd4; in_valid = 1; in_sample = 16'sd9999; tick();
    for (int i = 0; i < 4; i++) feed(300 + i);

    tag = "R3";
    go(1, 3);
    feed(300); feed(301); feed(302);

    tag = "R10";
    for (int p = 0; p < 16; p++) load(p, ((p % 2) ? -1 : 1) * (1200 - 60 * p));
    go(16, 60);
    for (int i = 0; i < 60; i++) feed(((i * 3779 + 17) % 4001) - 2000);
    tick(); tick();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule